// File: doc/BRIEF.md
# Double-to-Wide-Digit Significand Converter

This block conditions a 64-bit double-precision operand for an adder whose alignment works on wide digits instead of single bits. Each cycle it accepts one packed value and, two cycles later, presents a signed two's-complement significand together with a shortened exponent. The digit size is a power-of-two parameter `BASE`, with 64 as the default.

The first register stage restores the hidden leading one in front of the 52-bit fraction. It then uses the low lg(BASE) bits of the 11-bit exponent as a left shift of that 53-bit value. This leaves an exponent of 11 − lg(BASE) bits, which counts whole digits. Two zero bits on top of the shifted value hold the sign and the carry, so the significand is 54 + BASE bits wide (118 by default). The second register stage negates the significand when the input sign bit is set. Infinities, NaNs, denormals and rounding are not handled. An exponent field of zero is taken as the value zero.

Top module: `bdc_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_sig` and `out_exp` are all zero, whatever the input.
- R2: For an input with sign 0 and exponent field E ≠ 0, `out_sig` equals the 53-bit value {1, fraction} shifted left by (E mod BASE), zero-extended to 54 + BASE bits. Its top two bits are therefore 00.
- R3: `out_exp` equals the exponent field E shifted right by lg(BASE), that is, bits 62 down to 52 + lg(BASE) of the input word.
- R4: For an input with sign 1 (bit 63) and E ≠ 0, `out_sig` is the two's complement, modulo 2^(54+BASE), of the R2 value. Its top two bits are 11.
- R5: An input whose exponent field (bits 62..52) is 0 gives an all-zero `out_sig` and `out_exp`, for either sign and any fraction.
- R6: A value sampled at rising edge k appears on the outputs after rising edge k+2. Back-to-back inputs each give their own result, so one value is converted per cycle.
- R7: When E mod BASE is 0, the hidden one sits at bit 52 and bits 52..0 hold {1, fraction}. When E mod BASE is BASE−1, the hidden one sits at bit 51 + BASE, the highest bit below the two guard bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | 64 | Packed double: sign bit 63, exponent 62..52, fraction 51..0 |
| out_sig | output | 54+BASE | Signed two's-complement significand in wide digits |
| out_exp | output | 11−lg(BASE) | Exponent in units of BASE bits |

## Verification
The bench goes after the two ends of the pre-shift (low exponent bits all zero and all one). A converter that shifts by the wrong field, or that is one bit short, would put the hidden one in the wrong place or drop it off the top. Negative inputs are checked against a separately computed two's complement. That catches a design that only inverts without adding one, or that negates based on a stale sign. Zero-exponent inputs with a set sign and a non-zero fraction must come out as exact zero, so a design that lets the hidden bit or the sign leak through is flagged. Streams of distinct back-to-back values and a one-cycle-early probe catch a pipeline with the wrong depth or one that mixes neighbouring operands.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

    localparam int unsigned WORD_W = 64;
    localparam int unsigned EXP_W  = 11;
    localparam int unsigned FRAC_W = 52;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } dbl_t;

    function automatic int unsigned digit_bits(input int unsigned base);
        return $clog2(base);
    endfunction

    function automatic int unsigned red_exp_w(input int unsigned base);
        return EXP_W - $clog2(base);
    endfunction

    function automatic int unsigned wide_sig_w(input int unsigned base);
        return FRAC_W + 2 + base;
    endfunction

endpackage

// File: rtl/bdc_align.sv
module bdc_align
    import bdc_pkg::*;
#(
    parameter int unsigned BASE = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  dbl_t                          din,
    output logic                          neg_q,
    output logic [red_exp_w(BASE)-1:0]    exp_q,
    output logic [wide_sig_w(BASE)-1:0]   mag_q
);
    localparam int unsigned LG_B  = digit_bits(BASE);
    localparam int unsigned RED_W = red_exp_w(BASE);
    localparam int unsigned SIG_W = wide_sig_w(BASE);

    logic [LG_B-1:0]   shamt;
    logic [RED_W-1:0]  exp_n;
    logic [SIG_W-1:0]  mag_n;
    logic              is_zero;

    always_comb begin
        is_zero = (din.expo == '0);
        shamt   = din.expo[LG_B-1:0];
        if (is_zero) begin
            exp_n = '0;
            mag_n = '0;
        end else begin
            exp_n = din.expo[EXP_W-1:LG_B];
            mag_n = SIG_W'({1'b1, din.frac}) << shamt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            neg_q <= 1'b0;
            exp_q <= '0;
            mag_q <= '0;
        end else begin
            neg_q <= din.sign & ~is_zero;
            exp_q <= exp_n;
            mag_q <= mag_n;
        end
    end

endmodule

// File: rtl/bdc_negate.sv
module bdc_negate #(
    parameter int unsigned SIG_W = 118,
    parameter int unsigned RED_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              neg,
    input  logic [RED_W-1:0]  exp_in,
    input  logic [SIG_W-1:0]  mag,
    output logic [RED_W-1:0]  exp_q,
    output logic [SIG_W-1:0]  sig_q
);
    logic [SIG_W-1:0] sig_n;

    always_comb begin
        sig_n = neg ? (~mag + SIG_W'(1)) : mag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q <= '0;
            sig_q <= '0;
        end else begin
            exp_q <= exp_in;
            sig_q <= sig_n;
        end
    end

endmodule

// File: rtl/bdc_top.sv
module bdc_top
    import bdc_pkg::*;
#(
    parameter int unsigned BASE = 64
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [63:0]                         in_word,
    output logic [bdc_pkg::wide_sig_w(BASE)-1:0] out_sig,
    output logic [bdc_pkg::red_exp_w(BASE)-1:0]  out_exp
);
    localparam int unsigned RED_W = red_exp_w(BASE);
    localparam int unsigned SIG_W = wide_sig_w(BASE);

    dbl_t              din;
    logic              s1_neg;
    logic [RED_W-1:0]  s1_exp;
    logic [SIG_W-1:0]  s1_mag;

    assign din = dbl_t'(in_word);

    bdc_align #(.BASE(BASE)) u_align (
        .clk   (clk),
        .rst   (rst),
        .din   (din),
        .neg_q (s1_neg),
        .exp_q (s1_exp),
        .mag_q (s1_mag)
    );

    bdc_negate #(.SIG_W(SIG_W), .RED_W(RED_W)) u_negate (
        .clk    (clk),
        .rst    (rst),
        .neg    (s1_neg),
        .exp_in (s1_exp),
        .mag    (s1_mag),
        .exp_q  (out_exp),
        .sig_q  (out_sig)
    );

endmodule

// File: rtl/bdc_check.sv
module bdc_check
    import bdc_pkg::*;
#(
    parameter int unsigned BASE = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [63:0]                   in_word,
    input  logic [wide_sig_w(BASE)-1:0]   out_sig,
    input  logic [red_exp_w(BASE)-1:0]    out_exp
);
    localparam int unsigned LG_B  = digit_bits(BASE);
    localparam int unsigned SIG_W = wide_sig_w(BASE);

    logic [1:0] warm_cnt = 2'd0;
    logic       rst_seen = 1'b0;
    logic       warm;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst)                  warm_cnt <= 2'd0;
        else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
    end

    assign warm = (warm_cnt == 2'd2);

    // R1: outputs cleared after a reset edge
    always @(negedge clk) begin
        if (rst_seen) begin
            p_reset_clear_r1: assert (out_sig == '0 && out_exp == '0)
                else $error("outputs not cleared by reset");
        end
    end

    p_zero_exp_r5: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(in_word[62:52], 2) == '0) |-> (out_sig == '0 && out_exp == '0));

    p_exp_drop_r3: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_exp == $past(in_word[62:52+LG_B], 2)));

    p_guard_pos_r2: assert property (@(posedge clk) disable iff (rst)
        (warm && !$past(in_word[63], 2)) |-> (out_sig[SIG_W-1:SIG_W-2] == 2'b00));

    p_guard_neg_r4: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(in_word[63], 2) && $past(in_word[62:52], 2) != '0)
        |-> (out_sig[SIG_W-1:SIG_W-2] == 2'b11));

    p_noshift_r7: assert property (@(posedge clk) disable iff (rst)
        (warm && !$past(in_word[63], 2) && $past(in_word[62:52], 2) != '0
              && $past(in_word[52+LG_B-1:52], 2) == '0)
        |-> (out_sig[52:0] == {1'b1, $past(in_word[51:0], 2)}));

endmodule

bind bdc_top bdc_check #(.BASE(BASE)) u_bdc_check (
    .clk     (clk),
    .rst     (rst),
    .in_word (in_word),
    .out_sig (out_sig),
    .out_exp (out_exp)
);

// File: tb/test_bdc_top.sv
`timescale 1ns/1ps
module test_bdc_top;
    localparam int unsigned BASE  = 64;
    localparam int unsigned LG_B  = $clog2(BASE);
    localparam int unsigned SIG_W = 54 + BASE;
    localparam int unsigned RED_W = 11 - LG_B;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [63:0]       in_word = '0;
    logic [SIG_W-1:0]  out_sig;
    logic [RED_W-1:0]  out_exp;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bdc_top #(.BASE(BASE)) i_bdc_top (
        .clk(clk), .rst(rst), .in_word(in_word),
        .out_sig(out_sig), .out_exp(out_exp)
    );

    function automatic logic [SIG_W-1:0] ref_sig(input logic [63:0] w);
        int unsigned e;
        logic [SIG_W-1:0] m;
        e = int'(w[62:52]);
        if (e == 0) return '0;
        m = (SIG_W'(1) << 52) | SIG_W'(w[51:0]);
        m = m << (e % BASE);
        if (w[63]) m = SIG_W'(0) - m;
        return m;
    endfunction

    function automatic logic [RED_W-1:0] ref_exp(input logic [63:0] w);
        return RED_W'(int'(w[62:52]) / BASE);
    endfunction

    task automatic check_out(input string req, input logic [63:0] w);
        logic [SIG_W-1:0] es;
        logic [RED_W-1:0] ee;
        es = ref_sig(w);
        ee = ref_exp(w);
        checks++;
        if (out_sig !== es) begin
            errors++;
            $display("FAIL %s sig in=%h got=%h exp=%h", req, w, out_sig, es);
        end
        checks++;
        if (out_exp !== ee) begin
            errors++;
            $display("FAIL %s exp in=%h got=%h exp=%h", req, w, out_exp, ee);
        end
    endtask

    task automatic run_one(input string req, input logic [63:0] w);
        @(negedge clk) in_word = w;
        @(negedge clk);
        @(negedge clk);
        check_out(req, w);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        @(negedge clk) in_word = 64'hBFF8_1234_5678_9ABC;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (out_sig !== '0 || out_exp !== '0) begin
            errors++;
            $display("FAIL R1 got=%h/%h exp=0/0", out_sig, out_exp);
        end
        @(negedge clk) rst = 1'b0;
        checks++;
        if (out_sig !== '0 || out_exp !== '0) begin
            errors++;
            $display("FAIL R1 after release got=%h/%h exp=0/0", out_sig, out_exp);
        end
    endtask

    task automatic t_positive;
        run_one("R2", 64'h3FF0_0000_0000_0000);
        run_one("R2", 64'h4000_0000_0000_0000);
        run_one("R2", 64'h4009_21FB_5444_2D18);
        run_one("R3", 64'h7FEF_FFFF_FFFF_FFFF);
        run_one("R3", 64'h0010_0000_0000_0001);
    endtask

    task automatic t_negative;
        run_one("R4", 64'hBFF0_0000_0000_0000);
        run_one("R4", 64'hC00C_0000_0000_0000);
        run_one("R4", 64'hFFEF_FFFF_FFFF_FFFF);
        run_one("R4", 64'h8010_0000_0000_0000);
    endtask

    task automatic t_shift_ends;
        logic [63:0] w;
        w = {1'b0, 11'(BASE), 52'h0};
        run_one("R7", w);
        checks++;
        if (out_sig !== (SIG_W'(1) << 52)) begin
            errors++;
            $display("FAIL R7 low0 got=%h exp=%h", out_sig, SIG_W'(1) << 52);
        end
        w = {1'b0, 11'(2*BASE-1), 52'h0};
        run_one("R7", w);
        checks++;
        if (out_sig !== (SIG_W'(1) << (51 + BASE))) begin
            errors++;
            $display("FAIL R7 lowmax got=%h exp=%h", out_sig, SIG_W'(1) << (51 + BASE));
        end
        run_one("R7", {1'b0, 11'(3*BASE-1), 52'hF_FFFF_FFFF_FFFF});
    endtask

    task automatic t_zero_exp;
        run_one("R5", 64'h8000_0000_0000_0000);
        run_one("R5", 64'h800F_FFFF_FFFF_FFFF);
        run_one("R5", 64'h0000_0000_0000_0001);
    endtask

    task automatic t_stream;
        logic [63:0] v [8];
        v[0] = 64'h3FF0_0000_0000_0000; v[1] = 64'hBFE0_0000_0000_0001;
        v[2] = 64'h0000_0000_0000_0000; v[3] = 64'h4123_4567_89AB_CDEF;
        v[4] = 64'hC7F0_0000_0000_0000; v[5] = 64'h8000_0000_0000_0005;
        v[6] = 64'h3CB0_0000_0000_0000; v[7] = 64'hFFE0_0000_0000_0000;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i >= 2) check_out("R6", v[i-2]);
            if (i < 8) in_word = v[i];
        end
        @(negedge clk) in_word = 64'h4000_0000_0000_0000;
        @(negedge clk) in_word = 64'hC000_0000_0000_0000;
        check_out("R6", 64'hFFE0_0000_0000_0000);
        @(negedge clk);
        check_out("R6", 64'h4000_0000_0000_0000);
        @(negedge clk);
        check_out("R6", 64'hC000_0000_0000_0000);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset;
        t_positive;
        t_negative;
        t_shift_ends;
        t_zero_exp;
        t_stream;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule